// File: doc/BRIEF.md
# Bit-Serial Two's Complement Negator

This block negates a binary integer that streams in one bit per clock, least significant bit first, and streams the negated value out on the same cycle as each input bit. It keeps a single bit of state: a mode flag that records whether a 1 has already gone by in the current word. While the flag is clear, each input bit appears unchanged at the output. Once a 1 has been seen, every later bit of that word comes out inverted. The output bit is formed from the present flag and the input bit, never from the flag's next value.

A caller marks the first bit of each word with a start strobe, and a valid qualifier marks the cycles that carry a bit. The word length is whatever distance the caller leaves between two start strobes. Valid-low cycles may be inserted anywhere in a word without disturbing the result.

Top module: `ser_negator`

## Requirements
- R1: After reset the mode flag is clear, so a word sent without any start strobe is negated as if it had been started.
- R2: For a word of n bits sent LSB first with the start strobe on its first bit, the n output bits read LSB first equal (2^n - value) mod 2^n.
- R3: Every input bit up to and including the first 1 of the word appears unchanged at the output on the same cycle.
- R4: Every input bit after the first 1 of the word appears inverted at the output on the same cycle, and the flag stays set until the next start.
- R5: A start strobe on a valid cycle treats that cycle's bit as if the flag were clear, whatever the previous word left behind, with no idle cycle needed between words.
- R6: On a cycle with the valid qualifier low, the output bit is 0 and the flag keeps its value.
- R7: A start strobe on a cycle with the valid qualifier low has no effect: the flag is left as it was.
- R8: An all-zero word produces all-zero output and leaves the flag clear, so bits that follow without a start are treated as a fresh word.
- R9: A word whose only 1 is its most significant bit comes out equal to itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_start_i | input | 1 | Marks the first bit of a word; acts only when bit_valid_i is high |
| bit_i | input | 1 | Serial input bit, LSB first |
| bit_valid_i | input | 1 | High on cycles that carry a bit |
| bit_o | output | 1 | Serial negated bit, same cycle as bit_i; 0 when bit_valid_i is low |

## Verification
The bench drives back-to-back words whose predecessor left the flag set, so a design that cleared the flag one cycle late would invert the first bit of the new word. It sends the single-1-at-the-top word and single-bit words, where a design that updated the output from the next flag value would invert the first 1 itself. It threads valid-low gaps and stray start strobes on those gaps through words, which a design that let invalid cycles touch the flag would turn into wrong inverted or copied bits. An all-zero word followed by unstarted bits exposes a flag that sets on zeros.

// File: rtl/ser_neg_pkg.sv
package ser_neg_pkg;

    // One serial beat as seen at the block's input
    typedef struct packed {
        logic start;
        logic data;
        logic valid;
    } beat_t;

    // Negation mode: copy until the first 1, invert afterwards
    typedef enum logic {
        MODE_COPY   = 1'b0,
        MODE_INVERT = 1'b1
    } mode_e;

    // Mode that applies to the current beat (start forces copy)
    function automatic mode_e present_mode(mode_e held, beat_t b);
        if (b.valid && b.start) begin
            return MODE_COPY;
        end
        return held;
    endfunction

    // Mode to hold after the current beat
    function automatic mode_e following_mode(mode_e now, beat_t b);
        if (!b.valid) begin
            return now;
        end
        if (b.data || (now == MODE_INVERT)) begin
            return MODE_INVERT;
        end
        return MODE_COPY;
    endfunction

    // Output bit for the current beat
    function automatic logic negated_bit(mode_e now, beat_t b);
        return b.valid & (b.data ^ (now == MODE_INVERT));
    endfunction

endpackage

// File: rtl/ser_neg_mode_reg.sv
module ser_neg_mode_reg
    import ser_neg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    output mode_e held_mode,
    output mode_e now_mode
);

    mode_e mode_q;
    mode_e mode_d;

    always_comb begin
        now_mode = present_mode(mode_q, beat);
        mode_d   = following_mode(now_mode, beat);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_COPY;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign held_mode = mode_q;

endmodule

// File: rtl/ser_neg_out.sv
module ser_neg_out
    import ser_neg_pkg::*;
(
    input  beat_t beat,
    input  mode_e now_mode,
    output logic  out_bit
);

    always_comb begin
        out_bit = negated_bit(now_mode, beat);
    end

endmodule

// File: rtl/ser_negator.sv
module ser_negator
    import ser_neg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic word_start_i,
    input  logic bit_i,
    input  logic bit_valid_i,
    output logic bit_o
);

    beat_t beat;
    mode_e mode_q;
    mode_e mode_now;

    always_comb begin
        beat.start = word_start_i;
        beat.data  = bit_i;
        beat.valid = bit_valid_i;
    end

    ser_neg_mode_reg u_mode (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .held_mode (mode_q),
        .now_mode  (mode_now)
    );

    ser_neg_out u_out (
        .beat     (beat),
        .now_mode (mode_now),
        .out_bit  (bit_o)
    );

endmodule

// File: rtl/ser_negator_chk.sv
module ser_negator_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic din,
    input logic vld,
    input logic dout,
    input logic mode
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> !mode);

    // R6
    idle_output_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |-> !dout);

    // R6
    idle_holds_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(mode));

    // R3
    copy_passes_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !start && !mode) |-> (dout == din));

    // R4
    invert_flips_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !start && mode) |-> (dout != din));

    // R4
    invert_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !start && mode) |=> mode);

    // R5
    start_copies_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && start) |-> (dout == din));

    // R3
    one_sets_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && din) |=> mode);

    // R8
    zero_start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && start && !din) |=> !mode);

endmodule

bind ser_negator ser_negator_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (word_start_i),
    .din   (bit_i),
    .vld   (bit_valid_i),
    .dout  (bit_o),
    .mode  (mode_q)
);

// File: tb/ser_negator_bench.sv
module ser_negator_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_start_i = 1'b0;
    logic bit_i = 1'b0;
    logic bit_valid_i = 1'b0;
    logic bit_o;

    int checks = 0;
    int failures = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ser_negator u_ser_negator (
        .clk          (clk),
        .rst          (rst),
        .word_start_i (word_start_i),
        .bit_i        (bit_i),
        .bit_valid_i  (bit_valid_i),
        .bit_o        (bit_o)
    );

    // Monitor: compares at the falling edge, after inputs settled
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_valid_i) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R2 unexpected valid beat: actual=%0b expected=none", bit_o);
                end else begin
                    logic  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (bit_o !== e) begin
                        failures++;
                        $display("FAIL %s actual=%0b expected=%0b", t, bit_o, e);
                    end
                end
            end else begin
                checks++;
                if (bit_o !== 1'b0) begin
                    failures++;
                    $display("FAIL R6 idle output actual=%0b expected=0", bit_o);
                end
            end
        end
    end

    task automatic idle(input int cycles, input logic stray_start);
        for (int k = 0; k < cycles; k++) begin
            word_start_i = stray_start;
            bit_valid_i  = 1'b0;
            bit_i        = 1'b1;
            @(posedge clk);
            #1;
        end
        word_start_i = 1'b0;
    endtask

    // Driver: sends one word LSB first; prior_set means the flag is
    // expected to be set already (no start, bits all inverted)
    task automatic send_word(input logic [15:0] w, input int n,
                             input logic use_start, input logic prior_set,
                             input logic gaps, input string req);
        logic [15:0] neg;
        int first_one;
        neg = (~w + 16'd1);
        first_one = n;
        for (int i = n - 1; i >= 0; i--) begin
            if (w[i]) first_one = i;
        end
        for (int i = 0; i < n; i++) begin
            if (prior_set) begin
                exp_q.push_back(~w[i]);
                tag_q.push_back({req, "/R4 bit ", $sformatf("%0d", i)});
            end else begin
                exp_q.push_back(neg[i]);
                tag_q.push_back({req, (i <= first_one) ? "/R3 bit " : "/R4 bit ",
                                 $sformatf("%0d", i)});
            end
            word_start_i = use_start && (i == 0);
            bit_i        = w[i];
            bit_valid_i  = 1'b1;
            @(posedge clk);
            #1;
            if (gaps) idle(1, 1'b0);
        end
        word_start_i = 1'b0;
        bit_valid_i  = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        idle(2, 1'b0);                       // reset state, R6
        send_word(16'h0006, 4, 1'b0, 1'b0, 1'b0, "R1");
        send_word(16'h002D, 8, 1'b1, 1'b0, 1'b0, "R2");
        send_word(16'h0001, 16, 1'b1, 1'b0, 1'b0, "R2");
        send_word(16'hFFFF, 16, 1'b1, 1'b0, 1'b0, "R2");
        send_word(16'h0007, 3, 1'b1, 1'b0, 1'b1, "R6");
        send_word(16'h0080, 8, 1'b1, 1'b0, 1'b0, "R9");
        send_word(16'h0000, 8, 1'b1, 1'b0, 1'b0, "R8");
        send_word(16'h0005, 8, 1'b0, 1'b0, 1'b0, "R8");
        send_word(16'h0001, 4, 1'b1, 1'b0, 1'b0, "R5");
        send_word(16'h0003, 4, 1'b1, 1'b0, 1'b0, "R5");
        send_word(16'h0002, 2, 1'b1, 1'b0, 1'b0, "R7");
        idle(1, 1'b1);
        send_word(16'h0002, 2, 1'b0, 1'b1, 1'b0, "R7");
        send_word(16'h0001, 1, 1'b1, 1'b0, 1'b0, "R9");
        send_word(16'h0000, 1, 1'b1, 1'b0, 1'b0, "R8");
        send_word(16'h0B3C, 12, 1'b1, 1'b0, 1'b1, "R2");
        idle(2, 1'b0);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2 leftover expected beats actual=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule